// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This block turns a single PWM command into the two gate enables of a synchronous buck half-bridge: a high-side drive that follows PWM in phase and a low-side drive that runs in antiphase. The two drives are never on together. The dead time between them is adaptive rather than a fixed count. Each turn-on is held back until a sensed condition says the opposite switch has really let go. Before the low side may close, the switch node must have dropped below its threshold. Before the high side may close, the low-side gate must have dropped below its threshold. Both conditions arrive as already-digitized comparator flags, and each passes through a two-flop synchronizer.

Every transition also carries a fixed propagation delay, given as a clock-cycle parameter. There is one such parameter for each of the four edges. A safety timer guards the case where the high-side switch fails to open. If the switch-node flag never arrives, the low side is forced on once a parameterized number of cycles has passed, and a one-cycle timeout pulse is raised. Deasserting the enable puts both drives low.

Top module: `dtg_gate_ctrl`

## Requirements
- R1: While enabled and settled, `hs_drv` equals `pwm_in` and `ls_drv` equals its complement.
- R2: In reset, and from one cycle after `en` is sampled low, `hs_drv`, `ls_drv` and `tmo_pulse` are all 0.
- R3: When `pwm_in` is sampled low with the high side on, `hs_drv` falls exactly HS_OFF_DLY+1 clock edges later.
- R4: After `hs_drv` falls, `ls_drv` stays low until `sw_low` is 1. It rises exactly LS_ON_DLY+3 edges after `sw_low` goes to 1, which includes two synchronizer stages.
- R5: If `sw_low` stays 0, `ls_drv` rises exactly SAFE_CYC edges after `hs_drv` fell. In that same cycle `tmo_pulse` is 1, and it is high for one cycle only.
- R6: When `pwm_in` is sampled high with the low side on, `ls_drv` falls exactly LS_OFF_DLY+1 edges later.
- R7: After `ls_drv` falls, `hs_drv` stays low for as long as `lg_low` is 0. It rises exactly HS_ON_DLY+3 edges after `lg_low` goes to 1.
- R8: `hs_drv` and `ls_drv` are never 1 in the same cycle, including during a safety override.
- R9: If `pwm_in` reverses while a turn-on is waiting for its flag or its delay, that turn-on is dropped. The opposite sequence then starts from the current state, with both drives low.
- R10: When `en` rises, both drives start low and the normal sequence for the current PWM level follows. With PWM low and no switch-node flag, the low side comes on by the safety timer SAFE_CYC edges after the first enabled edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Enable; low forces both drives off |
| pwm_in | input | 1 | PWM command, synchronous to clk |
| sw_low | input | 1 | Switch node below its threshold (asynchronous) |
| lg_low | input | 1 | Low-side gate below its threshold (asynchronous) |
| hs_drv | output | 1 | High-side gate enable |
| ls_drv | output | 1 | Low-side gate enable |
| tmo_pulse | output | 1 | One-cycle pulse when the safety override fires |

## Verification
The assertions take for granted that `pwm_in` and `en` are synchronous to `clk`. They also assume the comparator flags behave as a real bridge would: the low-gate flag drops while the low side is on, and the switch-node flag drops while the high side is on. The stimulus changes every input only at the falling clock edge. It clears the matching flag before each turn-off, so the interlock waits are exercised with the flag absent. Flags are raised later at known cycles, so latency can be counted exactly through the synchronizer.

// File: rtl/dtg_pkg.sv
// Shared types for the adaptive dead-time gate controller.
// Assumes nothing beyond a single clock domain for the sequencer.
package dtg_pkg;

    // Sequencer states; drive levels are decoded from these
    typedef enum logic [3:0] {
        ST_IDLE,     // disabled, both drives low
        ST_HS_ON,    // high side conducting
        ST_HS_FALL,  // high side still on, turn-off delay running
        ST_WAIT_SW,  // both low, waiting for switch node or timer
        ST_LS_RISE,  // both low, low-side turn-on delay running
        ST_LS_ON,    // low side conducting
        ST_LS_FALL,  // low side still on, turn-off delay running
        ST_WAIT_LG,  // both low, waiting for low gate to discharge
        ST_HS_RISE   // both low, high-side turn-on delay running
    } dtg_state_e;

endpackage

// File: rtl/dtg_sync.sv
// Multi-stage synchronizer for a vector of asynchronous level flags.
// Assumes the flags are slow levels; no pulse capture is attempted.
module dtg_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    logic [N-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the raw flags
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= din;
            end
        end else begin : g_next
            // Later stages shift the previous stage along
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/dtg_safety_timer.sv
// Safety timer: counts cycles while run is high, clears when run is low.
// The expire output is high in the cycle where LIMIT cycles of run are complete.
// Assumes LIMIT >= 1.
module dtg_safety_timer #(
    parameter int LIMIT = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt;

    // Count while armed; saturate at the terminal value
    always_ff @(posedge clk) begin
        if (!rst_n || !run)            cnt <= '0;
        else if (cnt != W'(LIMIT - 1)) cnt <= cnt + W'(1);
    end

    assign expire = run && (cnt == W'(LIMIT - 1));

endmodule

// File: rtl/dtg_seq.sv
// Interlock sequencer: walks turn-off delay, sensed wait and turn-on delay for
// each PWM edge, and falls back to the safety timer on the low-side turn-on.
// Assumes pwm and en are synchronous and the flags are already synchronized.
module dtg_seq
    import dtg_pkg::*;
#(
    parameter int HS_OFF_DLY = 2,
    parameter int LS_ON_DLY  = 2,
    parameter int LS_OFF_DLY = 2,
    parameter int HS_ON_DLY  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pwm,
    input  logic sw_lo,
    input  logic lg_lo,
    input  logic expire,
    output logic tmr_run,
    output logic hs,
    output logic ls,
    output logic tmo
);

    localparam int MAX_A = (HS_OFF_DLY > LS_ON_DLY)  ? HS_OFF_DLY : LS_ON_DLY;
    localparam int MAX_B = (LS_OFF_DLY > HS_ON_DLY)  ? LS_OFF_DLY : HS_ON_DLY;
    localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAX_D + 2);

    dtg_state_e    st, st_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          fire;

    // Next-state decision for every state; disable overrides all
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        fire  = 1'b0;
        if (!en) begin
            st_n = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: st_n = pwm ? ST_WAIT_LG : ST_WAIT_SW;
                ST_HS_ON: if (!pwm) begin
                    if (HS_OFF_DLY == 0) st_n = ST_WAIT_SW;
                    else begin st_n = ST_HS_FALL; cnt_n = CW'(1); end
                end
                ST_HS_FALL: begin
                    if (pwm)                           st_n = ST_HS_ON;
                    else if (cnt >= CW'(HS_OFF_DLY))   st_n = ST_WAIT_SW;
                    else                               cnt_n = cnt + CW'(1);
                end
                ST_WAIT_SW: begin
                    if (pwm) st_n = ST_WAIT_LG;
                    else if (sw_lo) begin
                        if (LS_ON_DLY == 0) st_n = ST_LS_ON;
                        else begin st_n = ST_LS_RISE; cnt_n = CW'(1); end
                    end else if (expire) begin
                        st_n = ST_LS_ON;
                        fire = 1'b1;
                    end
                end
                ST_LS_RISE: begin
                    if (pwm)                           st_n = ST_WAIT_LG;
                    else if (cnt >= CW'(LS_ON_DLY))    st_n = ST_LS_ON;
                    else                               cnt_n = cnt + CW'(1);
                end
                ST_LS_ON: if (pwm) begin
                    if (LS_OFF_DLY == 0) st_n = ST_WAIT_LG;
                    else begin st_n = ST_LS_FALL; cnt_n = CW'(1); end
                end
                ST_LS_FALL: begin
                    if (!pwm)                          st_n = ST_LS_ON;
                    else if (cnt >= CW'(LS_OFF_DLY))   st_n = ST_WAIT_LG;
                    else                               cnt_n = cnt + CW'(1);
                end
                ST_WAIT_LG: begin
                    if (!pwm) st_n = ST_WAIT_SW;
                    else if (lg_lo) begin
                        if (HS_ON_DLY == 0) st_n = ST_HS_ON;
                        else begin st_n = ST_HS_RISE; cnt_n = CW'(1); end
                    end
                end
                ST_HS_RISE: begin
                    if (!pwm)                          st_n = ST_WAIT_SW;
                    else if (cnt >= CW'(HS_ON_DLY))    st_n = ST_HS_ON;
                    else                               cnt_n = cnt + CW'(1);
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // State, delay counter and timeout pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
            tmo <= 1'b0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            tmo <= fire;
        end
    end

    assign tmr_run = (st == ST_WAIT_SW);
    assign hs      = (st == ST_HS_ON) || (st == ST_HS_FALL);
    assign ls      = (st == ST_LS_ON) || (st == ST_LS_FALL);

endmodule

// File: rtl/dtg_gate_ctrl.sv
// Adaptive dead-time gate controller for one synchronous buck half-bridge.
// Synchronizes the two comparator flags, runs the interlock sequencer and
// the safety timer. Assumes pwm_in and en are synchronous to clk.
module dtg_gate_ctrl #(
    parameter int HS_OFF_DLY  = 2,
    parameter int LS_ON_DLY   = 2,
    parameter int LS_OFF_DLY  = 2,
    parameter int HS_ON_DLY   = 2,
    parameter int SAFE_CYC    = 30,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic pwm_in,
    input  logic sw_low,
    input  logic lg_low,
    output logic hs_drv,
    output logic ls_drv,
    output logic tmo_pulse
);

    logic [1:0] flags_s;
    logic       tmr_run;
    logic       expire;

    dtg_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({lg_low, sw_low}),
        .dout (flags_s)
    );

    dtg_safety_timer #(.LIMIT(SAFE_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .expire(expire)
    );

    dtg_seq #(
        .HS_OFF_DLY(HS_OFF_DLY),
        .LS_ON_DLY (LS_ON_DLY),
        .LS_OFF_DLY(LS_OFF_DLY),
        .HS_ON_DLY (HS_ON_DLY)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .pwm    (pwm_in),
        .sw_lo  (flags_s[0]),
        .lg_lo  (flags_s[1]),
        .expire (expire),
        .tmr_run(tmr_run),
        .hs     (hs_drv),
        .ls     (ls_drv),
        .tmo    (tmo_pulse)
    );

endmodule

// File: rtl/dtg_chk.sv
// Checker for the gate controller's port-level safety properties.
// Assumes synchronous active-low reset; attached to the top by bind.
module dtg_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic hs,
    input logic ls,
    input logic tmo
);

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs && ls));

    // R2
    dis_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!hs && !ls && !tmo));

    // R5
    tmo_with_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |-> $rose(ls));

    // R5
    tmo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |=> !tmo);

    // R7
    hs_rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs) |-> ($past(!ls) && $past(en)));

    // R4
    ls_rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls) |-> ($past(!hs) && $past(en)));

endmodule

bind dtg_gate_ctrl dtg_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .hs   (hs_drv),
    .ls   (ls_drv),
    .tmo  (tmo_pulse)
);

// File: tb/tb_dtg_gate_ctrl.sv
// Self-checking bench: steady-state vector table, then directed timing tests.
module tb_dtg_gate_ctrl;

    localparam int HS_OFF = 1;
    localparam int LS_ON  = 2;
    localparam int LS_OFF = 1;
    localparam int HS_ON  = 2;
    localparam int SAFE   = 12;

    logic clk = 1'b0;
    logic rst_n, en, pwm, sw, lg;
    logic hs, ls, tmo;
    int   checks = 0;
    int   fails  = 0;
    int   overlap = 0;

    always #2.5 clk = ~clk;

    dtg_gate_ctrl #(
        .HS_OFF_DLY(HS_OFF), .LS_ON_DLY(LS_ON), .LS_OFF_DLY(LS_OFF),
        .HS_ON_DLY(HS_ON), .SAFE_CYC(SAFE), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .pwm_in(pwm),
        .sw_low(sw), .lg_low(lg),
        .hs_drv(hs), .ls_drv(ls), .tmo_pulse(tmo)
    );

    // R8 monitor: count any cycle with both drives on
    always @(negedge clk) if (rst_n === 1'b1 && hs === 1'b1 && ls === 1'b1) overlap++;

    // vector: en, pwm, sw, lg, wait cycles, expected hs, expected ls
    typedef struct packed {
        logic en; logic pwm; logic sw; logic lg;
        logic [7:0] wt; logic hs; logic ls;
    } vec_t;
    localparam int NV = 9;
    localparam vec_t VT [NV] = '{
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'd3,  1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'd8,  1'b1, 1'b0},
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'd10, 1'b0, 1'b1},
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'd10, 1'b1, 1'b0},
        '{1'b0, 1'b1, 1'b0, 1'b1, 8'd3,  1'b0, 1'b0},
        '{1'b1, 1'b0, 1'b1, 1'b1, 8'd10, 1'b0, 1'b1},
        '{1'b1, 1'b1, 1'b0, 1'b1, 8'd10, 1'b1, 1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 8'd20, 1'b0, 1'b1},
        '{1'b0, 1'b0, 1'b0, 1'b1, 8'd3,  1'b0, 1'b0}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; pwm = 1'b0; sw = 1'b0; lg = 1'b1;
        tick(3);
        chk("R2 reset hs", hs, 1'b0);
        chk("R2 reset ls", ls, 1'b0);
        chk("R2 reset tmo", tmo, 1'b0);
        rst_n = 1'b1;

        // R1 / R2 steady-state table
        for (int i = 0; i < NV; i++) begin
            en = VT[i].en; pwm = VT[i].pwm; sw = VT[i].sw; lg = VT[i].lg;
            tick(int'(VT[i].wt));
            chk(VT[i].en ? "R1 table hs" : "R2 table hs", hs, VT[i].hs);
            chk(VT[i].en ? "R1 table ls" : "R2 table ls", ls, VT[i].ls);
        end

        // R3 and R4: high-side turn-off, then wait for switch-node flag
        en = 1'b1; pwm = 1'b1; sw = 1'b0; lg = 1'b1;
        tick(8);
        chk("R1 hs on", hs, 1'b1);
        pwm = 1'b0;
        tick(HS_OFF);     chk("R3 hs still on", hs, 1'b1);
        tick(1);          chk("R3 hs off", hs, 1'b0);
        tick(3);          chk("R4 ls waits", ls, 1'b0);
        sw = 1'b1;
        tick(LS_ON + 2);  chk("R4 ls before latency", ls, 1'b0);
        tick(1);          chk("R4 ls on", ls, 1'b1);

        // R6 and R7: low-side turn-off, hs held until gate flag
        sw = 1'b0; lg = 1'b0; pwm = 1'b1;
        tick(LS_OFF);     chk("R6 ls still on", ls, 1'b1);
        tick(1);          chk("R6 ls off", ls, 1'b0);
        tick(20);         chk("R7 hs held without flag", hs, 1'b0);
        lg = 1'b1;
        tick(HS_ON + 2);  chk("R7 hs before latency", hs, 1'b0);
        tick(1);          chk("R7 hs on", hs, 1'b1);

        // R5: safety override when switch node never falls
        pwm = 1'b0;
        tick(HS_OFF + 1); chk("R5 hs off", hs, 1'b0);
        tick(SAFE - 1);   chk("R5 ls before timeout", ls, 1'b0);
        chk("R5 tmo before timeout", tmo, 1'b0);
        tick(1);          chk("R5 ls forced", ls, 1'b1);
        chk("R5 tmo pulse", tmo, 1'b1);
        tick(1);          chk("R5 tmo one cycle", tmo, 1'b0);

        // R9: reversal while waiting for the low-gate flag
        lg = 1'b0; pwm = 1'b1;
        tick(LS_OFF + 1 + 3);
        chk("R9 hs not on", hs, 1'b0);
        pwm = 1'b0;
        tick(SAFE);       chk("R9 ls before timeout", ls, 1'b0);
        tick(1);          chk("R9 ls back on", ls, 1'b1);

        // R9: reversal while waiting for the switch-node flag
        lg = 1'b1; pwm = 1'b1;
        tick(LS_OFF + 2 + HS_ON); chk("R9 hs on", hs, 1'b1);
        pwm = 1'b0;
        tick(HS_OFF + 1 + 4);
        pwm = 1'b1;
        tick(HS_ON + 1);  chk("R9 hs still off", hs, 1'b0);
        chk("R9 ls never on", ls, 1'b0);
        tick(1);          chk("R9 hs restarts", hs, 1'b1);

        // R2 and R10: disable, then enable with PWM low and no flag
        en = 1'b0;
        tick(1);          chk("R2 disable hs", hs, 1'b0);
        pwm = 1'b0; sw = 1'b0; lg = 1'b1;
        tick(2);
        en = 1'b1;
        tick(SAFE);       chk("R10 ls waits", ls, 1'b0);
        chk("R10 hs low", hs, 1'b0);
        tick(1);          chk("R10 ls by timer", ls, 1'b1);
        chk("R10 tmo", tmo, 1'b1);

        // R8: no overlap observed anywhere
        checks++;
        if (overlap != 0) begin
            fails++;
            $display("FAIL R8 overlap: got %0d expected 0", overlap);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule